// File: doc/BRIEF.md
# Floating-Point Register Stack State

This block holds the architectural state of an eight-slot floating-point register stack. The state is the slot payloads, a 2-bit tag per physical slot, a top-of-stack pointer, a control word and a status word. Software and the surrounding execution unit see the slots through logical indices that are relative to the top pointer. Logical index i names physical slot (top + i) modulo the slot count. Payloads are opaque 64-bit values. No arithmetic is done here.

One command is accepted per clock through a command port. The commands are push, pop, exchange, free, store to a slot (optionally followed by a pop), load control word, load tag word, set condition codes and initialise. Any logical slot can be read at any time through a separate read index. The packed tag word, the control word with its decoded fields, and the status word with the live top pointer inserted are all combinational views of the current state. Stack overflow and underflow are the only faults this block raises.

Top module: `fpstk_state`

## Requirements
- R1: After reset, and one cycle after an initialise command (cmd_op 10), the block shows top_ptr 0, tag_word 0xFFFF, status_word 0x0000 and control_word 0x037F. Reset also clears every payload to 0. Initialise leaves the payloads unchanged.
- R2: With rd_idx = i, rd_data and rd_tag combinationally show the payload and the tag of physical slot (top_ptr + i) mod 8.
- R3: Push (cmd_op 1) decrements top_ptr modulo 8, writes cmd_data into the new top slot and sets that slot's tag to 00 (valid).
- R4: Pop (cmd_op 2) sets the tag of the top slot to 11 (empty) and increments top_ptr modulo 8. The payload is untouched.
- R5: A push whose target slot is not tagged empty still completes, and it sets status bits 6 (stack fault), 0 (invalid) and 9 (C1). A push into an empty slot leaves the status word unchanged.
- R6: A pop (cmd_op 2, or the pop half of cmd_op 6) of an empty top slot still completes, sets status bits 6 and 0, and clears bit 9 (C1). A pop of a non-empty slot leaves the status word unchanged. Fault bits stay set until initialise.
- R7: status_word carries the top pointer in bits 13:11, C0 in bit 8, C1 in bit 9, C2 in bit 10 and C3 in bit 14. Set-codes (cmd_op 9) loads C0, C1, C2 and C3 from cmd_word bits 0, 1, 2 and 3. The stored bits 13:11 never reach the output.
- R8: tag_word holds the tag of physical slot n in bits 2n+1:2n. Load-tags (cmd_op 8) unpacks cmd_word into the slot tags with the same placement.
- R9: Load-control (cmd_op 7) stores cmd_word as control_word. round_mode always shows control bits 11:10, and except_mask shows control bits 5:0.
- R10: Free (cmd_op 4) sets the tag of logical slot cmd_idx to empty. It leaves top_ptr and all payloads unchanged.
- R11: Exchange (cmd_op 3) swaps the payloads and the tags of logical slot 0 and logical slot cmd_idx.
- R12: Store (cmd_op 5) copies the payload and tag of logical slot 0 into logical slot cmd_idx. Store-pop (cmd_op 6) does the same copy and then pops. Opcodes 0 and 11 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 4 | Command code for this cycle |
| cmd_idx | input | 3 | Logical slot operand of the command |
| cmd_data | input | 64 | Payload for push |
| cmd_word | input | 16 | Control word, tag word or condition codes to load |
| rd_idx | input | 3 | Logical slot to read |
| rd_data | output | 64 | Payload of logical slot rd_idx |
| rd_tag | output | 2 | Tag of logical slot rd_idx |
| top_ptr | output | 3 | Current top-of-stack pointer |
| status_word | output | 16 | Status word with live top pointer |
| control_word | output | 16 | Current control word |
| tag_word | output | 16 | Packed tags of all physical slots |
| round_mode | output | 2 | Rounding mode field of the control word |
| except_mask | output | 6 | Exception mask field of the control word |

## Verification
The assertions check the pointer movement on every cycle. Each push moves the pointer down by one and each pop moves it up by one, and free leaves it still. They also check that a push leaves the new top slot valid, that the overflow and underflow flags appear exactly after a faulting push or pop, and that initialise restores the control and tag words. Some behaviour can only be shown by the bench's scenarios against its reference model. That covers payload movement under exchange and store, the bit placement of the packed tag and status words, the wrap of the pointer past slot 7, and the store-pop case where the target is slot 0 itself.

// File: rtl/fpstk_pkg.sv
`timescale 1ns/1ps
package fpstk_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_PUSH  = 4'd1,
        OP_POP   = 4'd2,
        OP_XCHG  = 4'd3,
        OP_FREE  = 4'd4,
        OP_STORE = 4'd5,
        OP_STPOP = 4'd6,
        OP_LDCW  = 4'd7,
        OP_LDTAG = 4'd8,
        OP_SETCC = 4'd9,
        OP_INIT  = 4'd10
    } stk_op_e;

    localparam logic [1:0] TAG_VALID = 2'b00;
    localparam logic [1:0] TAG_EMPTY = 2'b11;

    // status word bit positions
    localparam int SW_IE      = 0;
    localparam int SW_SF      = 6;
    localparam int SW_C0      = 8;
    localparam int SW_C1      = 9;
    localparam int SW_C2      = 10;
    localparam int SW_TOP_LSB = 11;
    localparam int SW_C3      = 14;

    localparam logic [15:0] CW_INIT = 16'h037F;

endpackage

// File: rtl/fpstk_slotmap.sv
`timescale 1ns/1ps
// Logical-to-physical slot translation relative to the top pointer.
module fpstk_slotmap #(
    parameter int PTR_W = 3
) (
    input  logic [PTR_W-1:0] top_i,
    input  logic [PTR_W-1:0] idx_i,
    output logic [PTR_W-1:0] phys_o
);
    // power-of-two slot count: modulo is plain wrap of the adder
    assign phys_o = top_i + idx_i;
endmodule

// File: rtl/fpstk_tagword.sv
`timescale 1ns/1ps
// Packs per-slot tags into one word and unpacks a word into tags.
module fpstk_tagword #(
    parameter int NREG = 8
) (
    input  logic [NREG-1:0][1:0] tags_i,
    output logic [2*NREG-1:0]    word_o,
    input  logic [2*NREG-1:0]    word_i,
    output logic [NREG-1:0][1:0] tags_o
);
    for (genvar n = 0; n < NREG; n++) begin : g_slot
        assign word_o[2*n +: 2] = tags_i[n];
        assign tags_o[n]        = word_i[2*n +: 2];
    end
endmodule

// File: rtl/fpstk_swbuild.sv
`timescale 1ns/1ps
// Builds the visible status word by inserting the live top pointer.
module fpstk_swbuild #(
    parameter int PTR_W = 3
) (
    input  logic [15:0]      sw_raw_i,
    input  logic [PTR_W-1:0] top_i,
    output logic [15:0]      sw_o
);
    import fpstk_pkg::*;

    always_comb begin
        sw_o = sw_raw_i;
        sw_o[SW_TOP_LSB +: PTR_W] = top_i;
    end
endmodule

// File: rtl/fpstk_state.sv
`timescale 1ns/1ps
module fpstk_state #(
    parameter int DATA_W = 64,
    parameter int NREG   = 8,
    localparam int PTR_W = $clog2(NREG),
    localparam int TAG_W = 2 * NREG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd_op,
    input  logic [PTR_W-1:0]  cmd_idx,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [15:0]       cmd_word,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_tag,
    output logic [PTR_W-1:0]  top_ptr,
    output logic [15:0]       status_word,
    output logic [15:0]       control_word,
    output logic [TAG_W-1:0]  tag_word,
    output logic [1:0]        round_mode,
    output logic [5:0]        except_mask
);
    import fpstk_pkg::*;

    typedef struct packed {
        logic [PTR_W-1:0]             top;
        logic [NREG-1:0][1:0]         tags;
        logic [NREG-1:0][DATA_W-1:0]  regs;
        logic [15:0]                  cw;
        logic [15:0]                  sw;
    } state_t;

    state_t st_q, st_d;

    logic [PTR_W-1:0]     sel_phys;
    logic [PTR_W-1:0]     rd_phys;
    logic [PTR_W-1:0]     below_phys;
    logic [NREG-1:0][1:0] tags_loaded;

    fpstk_slotmap #(.PTR_W(PTR_W)) u_map_cmd (
        .top_i(st_q.top), .idx_i(cmd_idx), .phys_o(sel_phys));

    fpstk_slotmap #(.PTR_W(PTR_W)) u_map_rd (
        .top_i(st_q.top), .idx_i(rd_idx), .phys_o(rd_phys));

    // logical index NREG-1 is the slot just below the top: push target
    fpstk_slotmap #(.PTR_W(PTR_W)) u_map_below (
        .top_i(st_q.top), .idx_i({PTR_W{1'b1}}), .phys_o(below_phys));

    fpstk_tagword #(.NREG(NREG)) u_tagword (
        .tags_i(st_q.tags), .word_o(tag_word),
        .word_i(cmd_word[TAG_W-1:0]), .tags_o(tags_loaded));

    fpstk_swbuild #(.PTR_W(PTR_W)) u_swbuild (
        .sw_raw_i(st_q.sw), .top_i(st_q.top), .sw_o(status_word));

    always_comb begin
        st_d = st_q;
        case (cmd_op)
            OP_PUSH: begin
                if (st_q.tags[below_phys] != TAG_EMPTY) begin
                    st_d.sw[SW_SF] = 1'b1;
                    st_d.sw[SW_IE] = 1'b1;
                    st_d.sw[SW_C1] = 1'b1;
                end
                st_d.regs[below_phys] = cmd_data;
                st_d.tags[below_phys] = TAG_VALID;
                st_d.top              = below_phys;
            end
            OP_POP: begin
                if (st_q.tags[st_q.top] == TAG_EMPTY) begin
                    st_d.sw[SW_SF] = 1'b1;
                    st_d.sw[SW_IE] = 1'b1;
                    st_d.sw[SW_C1] = 1'b0;
                end
                st_d.tags[st_q.top] = TAG_EMPTY;
                st_d.top            = st_q.top + 1'b1;
            end
            OP_XCHG: begin
                st_d.regs[st_q.top] = st_q.regs[sel_phys];
                st_d.tags[st_q.top] = st_q.tags[sel_phys];
                st_d.regs[sel_phys] = st_q.regs[st_q.top];
                st_d.tags[sel_phys] = st_q.tags[st_q.top];
            end
            OP_FREE: begin
                st_d.tags[sel_phys] = TAG_EMPTY;
            end
            OP_STORE, OP_STPOP: begin
                st_d.regs[sel_phys] = st_q.regs[st_q.top];
                st_d.tags[sel_phys] = st_q.tags[st_q.top];
                if (cmd_op == OP_STPOP) begin
                    if (st_q.tags[st_q.top] == TAG_EMPTY) begin
                        st_d.sw[SW_SF] = 1'b1;
                        st_d.sw[SW_IE] = 1'b1;
                        st_d.sw[SW_C1] = 1'b0;
                    end
                    st_d.tags[st_q.top] = TAG_EMPTY;
                    st_d.top            = st_q.top + 1'b1;
                end
            end
            OP_LDCW: begin
                st_d.cw = cmd_word;
            end
            OP_LDTAG: begin
                st_d.tags = tags_loaded;
            end
            OP_SETCC: begin
                st_d.sw[SW_C0] = cmd_word[0];
                st_d.sw[SW_C1] = cmd_word[1];
                st_d.sw[SW_C2] = cmd_word[2];
                st_d.sw[SW_C3] = cmd_word[3];
            end
            OP_INIT: begin
                st_d.top  = '0;
                st_d.tags = {NREG{TAG_EMPTY}};
                st_d.sw   = '0;
                st_d.cw   = CW_INIT;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.top  <= '0;
            st_q.tags <= {NREG{TAG_EMPTY}};
            st_q.regs <= '0;
            st_q.cw   <= CW_INIT;
            st_q.sw   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data      = st_q.regs[rd_phys];
    assign rd_tag       = st_q.tags[rd_phys];
    assign top_ptr      = st_q.top;
    assign control_word = st_q.cw;
    assign round_mode   = st_q.cw[11:10];
    assign except_mask  = st_q.cw[5:0];

    // R3: push moves the pointer down by one, wrapping
    assert_push_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == OP_PUSH |=> top_ptr == PTR_W'($past(top_ptr) - 1'b1));

    // R3: the slot written by a push is tagged valid
    assert_push_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == OP_PUSH |=> rd_idx != '0 || rd_tag == TAG_VALID);

    // R4: pop moves the pointer up by one, wrapping
    assert_pop_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_POP || cmd_op == OP_STPOP)
        |=> top_ptr == PTR_W'($past(top_ptr) + 1'b1));

    // R5: push onto an occupied slot raises fault with C1 set
    assert_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_PUSH && st_q.tags[below_phys] != TAG_EMPTY)
        |=> status_word[SW_SF] && status_word[SW_IE] && status_word[SW_C1]);

    // R6: pop of an empty slot raises fault with C1 cleared
    assert_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_POP && st_q.tags[st_q.top] == TAG_EMPTY)
        |=> status_word[SW_SF] && status_word[SW_IE] && !status_word[SW_C1]);

    // R10: free never moves the pointer
    assert_free_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == OP_FREE |=> $stable(top_ptr));

    // R1: initialise restores control and tag words
    assert_init_words_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == OP_INIT |=> control_word == CW_INIT && tag_word == '1
                              && top_ptr == '0);
endmodule

// File: tb/fpstk_state_test.sv
`timescale 1ns/1ps
module fpstk_state_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic [2:0]  cmd_idx = 3'd0;
    logic [63:0] cmd_data = 64'd0;
    logic [15:0] cmd_word = 16'd0;
    logic [2:0]  rd_idx = 3'd0;
    logic [63:0] rd_data;
    logic [1:0]  rd_tag;
    logic [2:0]  top_ptr;
    logic [15:0] status_word, control_word, tag_word;
    logic [1:0]  round_mode;
    logic [5:0]  except_mask;

    fpstk_state uut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_data(cmd_data), .cmd_word(cmd_word), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_tag(rd_tag), .top_ptr(top_ptr),
        .status_word(status_word), .control_word(control_word),
        .tag_word(tag_word), .round_mode(round_mode),
        .except_mask(except_mask));

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // reference model
    logic [63:0] m_reg [8];
    logic [1:0]  m_tag [8];
    logic [2:0]  m_top;
    logic [15:0] m_cw, m_sw;
    int          m_flt;

    function automatic logic [2:0] phys(input logic [2:0] i);
        return m_top + i;
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R11";
            4'd4: return "R10";
            4'd5, 4'd6: return "R12";
            4'd7: return "R9";
            4'd8: return "R8";
            4'd9: return "R7";
            4'd10: return "R1";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_init(input bit clr_data);
        for (int k = 0; k < 8; k++) begin
            m_tag[k] = 2'b11;
            if (clr_data) m_reg[k] = 64'd0;
        end
        m_top = 3'd0;
        m_sw  = 16'h0000;
        m_cw  = 16'h037F;
    endtask

    task automatic model_pop();
        if (m_tag[m_top] == 2'b11) begin
            m_sw  = (m_sw | 16'h0041) & ~16'h0200;
            m_flt = 2;
        end
        m_tag[m_top] = 2'b11;
        m_top = m_top + 3'd1;
    endtask

    task automatic model_step(input logic [3:0] op, input logic [2:0] idx,
                              input logic [63:0] dat, input logic [15:0] w);
        logic [2:0]  s;
        logic [63:0] tr;
        logic [1:0]  tt;
        m_flt = 0;
        s = phys(idx);
        case (op)
            4'd1: begin
                s = m_top - 3'd1;
                if (m_tag[s] != 2'b11) begin
                    m_sw  = m_sw | 16'h0241;
                    m_flt = 1;
                end
                m_reg[s] = dat; m_tag[s] = 2'b00; m_top = s;
            end
            4'd2: model_pop();
            4'd3: begin
                tr = m_reg[m_top]; tt = m_tag[m_top];
                m_reg[m_top] = m_reg[s]; m_tag[m_top] = m_tag[s];
                m_reg[s] = tr; m_tag[s] = tt;
            end
            4'd4: m_tag[s] = 2'b11;
            4'd5, 4'd6: begin
                m_reg[s] = m_reg[m_top]; m_tag[s] = m_tag[m_top];
                if (op == 4'd6) model_pop();
            end
            4'd7: m_cw = w;
            4'd8: for (int k = 0; k < 8; k++) m_tag[k] = w[2*k +: 2];
            4'd9: begin
                m_sw[8] = w[0]; m_sw[9] = w[1]; m_sw[10] = w[2]; m_sw[14] = w[3];
            end
            4'd10: model_init(1'b0);
            default: ;
        endcase
    endtask

    task automatic check_all(input string req_top);
        logic [15:0] exp_sw, exp_tw;
        string sreq;
        exp_sw = (m_sw & ~16'h3800) | (16'(m_top) << 11);
        for (int k = 0; k < 8; k++) exp_tw[2*k +: 2] = m_tag[k];
        sreq = (m_flt == 1) ? "R5" : (m_flt == 2) ? "R6" : "R7";
        chk(req_top, "top_ptr", 64'(top_ptr), 64'(m_top));
        chk(sreq, "status_word", 64'(status_word), 64'(exp_sw));
        chk("R9", "control_word", 64'(control_word), 64'(m_cw));
        chk("R9", "round_mode", 64'(round_mode), 64'(m_cw[11:10]));
        chk("R9", "except_mask", 64'(except_mask), 64'(m_cw[5:0]));
        chk("R8", "tag_word", 64'(tag_word), 64'(exp_tw));
        for (int k = 0; k < 8; k++) begin
            rd_idx = 3'(k);
            #0.2;
            chk("R2", "rd_data", rd_data, m_reg[phys(3'(k))]);
            chk("R2", "rd_tag", 64'(rd_tag), 64'(m_tag[phys(3'(k))]));
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [2:0] idx,
                         input logic [63:0] dat, input logic [15:0] w);
        cmd_op = op; cmd_idx = idx; cmd_data = dat; cmd_word = w;
        @(posedge clk);
        model_step(op, idx, dat, w);
        @(negedge clk);
        cmd_op = 4'd0;
        check_all(req_of(op));
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        model_init(1'b1);
        m_flt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_all("R1");

        // R3 pushes wrap around all slots, ninth push overflows (R5)
        for (int k = 0; k < 9; k++)
            apply(4'd1, 3'd0, 64'hA000_0000_0000_0000 + 64'(k), 16'd0);
        // R4 pops, ninth pop underflows (R6)
        for (int k = 0; k < 9; k++)
            apply(4'd2, 3'd0, 64'd0, 16'd0);

        apply(4'd10, 3'd0, 64'd0, 16'd0);          // R1 via initialise
        apply(4'd7, 3'd0, 64'd0, 16'h0C2A);        // R9 fields
        apply(4'd8, 3'd0, 64'd0, 16'h1B4E);        // R8 unpack
        apply(4'd10, 3'd0, 64'd0, 16'd0);
        apply(4'd9, 3'd0, 64'd0, 16'h000F);        // R7 all codes
        apply(4'd9, 3'd0, 64'd0, 16'h3805);        // R7 top bits ignored

        for (int k = 0; k < 4; k++)
            apply(4'd1, 3'd0, 64'h5500_0000_0000_0010 + 64'(k), 16'd0);
        apply(4'd3, 3'd2, 64'd0, 16'd0);           // R11 exchange
        apply(4'd4, 3'd1, 64'd0, 16'd0);           // R10 free
        apply(4'd5, 3'd5, 64'd0, 16'd0);           // R12 store to empty slot
        apply(4'd6, 3'd0, 64'd0, 16'd0);           // R12 store-pop onto itself
        apply(4'd13, 3'd3, 64'hFFFF, 16'hFFFF);    // R12 unused opcode

        for (int n = 0; n < 600; n++) begin
            logic [3:0] op;
            int r;
            r = int'($urandom % 100);
            if (r < 28)      op = 4'd1;
            else if (r < 52) op = 4'd2;
            else if (r < 98) op = 4'(3 + ($urandom % 7));
            else             op = 4'd10;
            apply(op, 3'($urandom), {$urandom, $urandom}, 16'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule